// File: doc/BRIEF.md
# Write Flush Trigger Controller

This block decides when a write buffer placed in front of a memory sequencer must discard its incoming data, and when real storage should begin. It runs in the write clock domain. It watches three sequencer signals: enable, write-not-read and done. It also watches the framing of the incoming write stream (valid, start of packet, sync and channel number) and, optionally, an external arming input. From these it drives one registered flush line to a downstream gate.

Two parameters shape its behaviour.

The first picks who starts a flush:
- In internal mode, the block flushes whenever the sequencer cannot take writes.
- In external mode, a rising edge on the arm input starts a flush. When the block is not armed, it leaves the stream alone.

The second picks what ends a flush:
- any valid beat;
- a valid start-of-packet beat;
- a start-of-packet beat that also carries sync;
- a start-of-packet beat on a chosen channel, where the channel number is taken modulo a configured channel count.

The flush line drops in the cycle after the releasing beat is seen on the stream. The gate sits behind a buffer of at least one cycle of latency, so that beat is kept.

Top module: `flush_trigger_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `flush` is 1 in every mode.
- R2: In internal mode, if the sequencer is not ready at a clock edge, `flush` is 1 after that edge. Not ready means `seq_en`=0, `seq_wr`=0 or `seq_done`=1.
- R3: Release mode "any beat", internal mode: if `flush` is 1, the sequencer is ready and `wr_valid` is 1 at an edge, `flush` is 0 after that edge. The releasing beat is kept.
- R4: Release mode "start of packet": only a beat with `wr_valid`=1 and `wr_sop`=1 releases the flush. A valid beat without sop leaves `flush` at 1.
- R5: Release mode "start with sync": release needs `wr_valid`, `wr_sop` and `wr_sync` all 1. A sop beat with `wr_sync`=0 leaves `flush` at 1.
- R6: Release mode "start on channel": release needs a valid sop beat for which `wr_chan` modulo NUM_CHAN equals START_CHAN. For example, with NUM_CHAN=4 and START_CHAN=2, channels 2 and 6 release and channel 1 does not.
- R7: In internal mode, once released, `flush` stays 0 while the sequencer stays ready, whatever the stream does.
- R8: In external mode, a rising edge of `ext_arm` sets `flush` to 1 after the edge on which it is seen, from any state. A rising edge is 0 at one clock edge and 1 at the next.
- R9: In external mode, an armed flush is ended by the selected release condition whether or not the sequencer is ready.
- R10: In external mode, after release, `flush` stays 0, through the end of the write and afterwards, until the next rising edge of `ext_arm`. Holding `ext_arm` high does not re-arm.
- R11: In internal mode, `ext_arm` has no effect on `flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_en | input | 1 | Sequencer enabled |
| seq_wr | input | 1 | Sequencer in write (1) or read (0) mode |
| seq_done | input | 1 | Sequencer reports the access range finished |
| ext_arm | input | 1 | External arming input, rising edge arms (external mode only) |
| wr_valid | input | 1 | Write stream beat valid |
| wr_sop | input | 1 | Write stream start of packet |
| wr_sync | input | 1 | Write stream sync marker |
| wr_chan | input | CHAN_W | Write stream channel number |
| flush | output | 1 | Registered flush command to the write buffer gate |

## Verification
The bench runs five configurations side by side on the same stimulus: the four internal release modes and one externally armed mode.

Directed cases target three release boundaries. A design with a broken release would drop flush too early or never drop it at all:
- a valid beat without sop in sop mode;
- a sop beat without sync in sync mode;
- channels 1 and 6 in channel mode. A design that compares the raw channel instead of the modulo value would ignore the aliased channel 6.

On the externally armed side, the directed cases check three things:
- a release while the sequencer is still idle;
- staying quiet after the write ends while `ext_arm` is held high. A level-sensitive design would re-arm here;
- a fresh edge that re-arms.

Random stimulus then compares each flush line, every cycle, against a state model built from the requirements.

// File: rtl/fltr_pkg.sv
package fltr_pkg;

    typedef enum logic [1:0] {
        REL_ANY      = 2'd0,
        REL_SOP      = 2'd1,
        REL_SOP_SYNC = 2'd2,
        REL_SOP_CHAN = 2'd3
    } rel_mode_e;

    typedef enum logic [1:0] {
        ST_FLUSH = 2'd0,
        ST_PASS  = 2'd1,
        ST_IDLE  = 2'd2
    } flt_state_e;

    typedef struct packed {
        flt_state_e state;
        logic       flush;
    } flt_regs_t;

endpackage

// File: rtl/fltr_release_match.sv
module fltr_release_match #(
    parameter fltr_pkg::rel_mode_e MODE       = fltr_pkg::REL_ANY,
    parameter int unsigned         CHAN_W     = 4,
    parameter int unsigned         NUM_CHAN   = 1,
    parameter int unsigned         START_CHAN = 0
) (
    input  logic              valid,
    input  logic              sop,
    input  logic              sync,
    input  logic [CHAN_W-1:0] chan,
    output logic              hit
);
    localparam int unsigned CHAN_SPAN = (NUM_CHAN < 1) ? 1 : NUM_CHAN;

    logic chan_ok;

    always_comb begin
        chan_ok = ((32'(chan) % CHAN_SPAN) == START_CHAN);
        case (MODE)
            fltr_pkg::REL_ANY:      hit = valid;
            fltr_pkg::REL_SOP:      hit = valid & sop;
            fltr_pkg::REL_SOP_SYNC: hit = valid & sop & sync;
            default:                hit = valid & sop & chan_ok;
        endcase
    end
endmodule

// File: rtl/fltr_arm_edge.sv
module fltr_arm_edge (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = arm;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign rise = arm & ~prev_q;
endmodule

// File: rtl/fltr_seq_status.sv
module fltr_seq_status (
    input  logic en,
    input  logic wr,
    input  logic done,
    output logic ready
);
    always_comb begin
        ready = en & wr & ~done;
    end
endmodule

// File: rtl/flush_trigger_ctrl.sv
module flush_trigger_ctrl #(
    parameter bit                  EXT_ARM    = 1'b0,
    parameter fltr_pkg::rel_mode_e REL_MODE   = fltr_pkg::REL_ANY,
    parameter int unsigned         CHAN_W     = 4,
    parameter int unsigned         NUM_CHAN   = 1,
    parameter int unsigned         START_CHAN = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_en,
    input  logic              seq_wr,
    input  logic              seq_done,
    input  logic              ext_arm,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic              wr_sync,
    input  logic [CHAN_W-1:0] wr_chan,
    output logic              flush
);
    import fltr_pkg::*;

    logic      seq_ready;
    logic      rel_hit;
    logic      arm_rise;
    logic      arm_evt;
    flt_regs_t r_d, r_q;

    fltr_seq_status i_status (
        .en    (seq_en),
        .wr    (seq_wr),
        .done  (seq_done),
        .ready (seq_ready)
    );

    fltr_release_match #(
        .MODE       (REL_MODE),
        .CHAN_W     (CHAN_W),
        .NUM_CHAN   (NUM_CHAN),
        .START_CHAN (START_CHAN)
    ) i_match (
        .valid (wr_valid),
        .sop   (wr_sop),
        .sync  (wr_sync),
        .chan  (wr_chan),
        .hit   (rel_hit)
    );

    fltr_arm_edge i_edge (
        .clk  (clk),
        .rst  (rst),
        .arm  (ext_arm),
        .rise (arm_rise)
    );

    assign arm_evt = EXT_ARM & arm_rise;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_FLUSH: begin
                if (arm_evt)
                    r_d.state = ST_FLUSH;
                else if (rel_hit && (EXT_ARM || seq_ready))
                    r_d.state = ST_PASS;
            end
            ST_PASS: begin
                if (arm_evt)
                    r_d.state = ST_FLUSH;
                else if (!seq_ready)
                    r_d.state = EXT_ARM ? ST_IDLE : ST_FLUSH;
            end
            ST_IDLE: begin
                if (arm_evt)
                    r_d.state = ST_FLUSH;
            end
            default: r_d.state = ST_FLUSH;
        endcase
        r_d.flush = (r_d.state == ST_FLUSH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_FLUSH;
            r_q.flush <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign flush = r_q.flush;
endmodule

// File: rtl/fltr_checker.sv
module fltr_checker #(
    parameter bit                  EXT_ARM  = 1'b0,
    parameter fltr_pkg::rel_mode_e REL_MODE = fltr_pkg::REL_ANY,
    parameter int unsigned         CHAN_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              seq_en,
    input logic              seq_wr,
    input logic              seq_done,
    input logic              ext_arm,
    input logic              wr_valid,
    input logic              wr_sop,
    input logic              wr_sync,
    input logic [CHAN_W-1:0] wr_chan,
    input logic              flush
);
    logic rdy;
    logic unused_ok;

    assign rdy       = seq_en & seq_wr & ~seq_done;
    assign unused_ok = ^{wr_sop, wr_sync, wr_chan};

    generate
        if (!EXT_ARM) begin : g_int
            AST_INT_NOT_READY_FLUSH: assert property (@(posedge clk) disable iff (rst)
                !rdy |=> flush);                                                  // R2
            AST_INT_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
                (!flush && rdy) |=> !flush);                                      // R7
            if (REL_MODE == fltr_pkg::REL_ANY) begin : g_any
                AST_ANY_BEAT_RELEASE: assert property (@(posedge clk) disable iff (rst)
                    (flush && rdy && wr_valid) |=> !flush);                       // R3
            end
        end else begin : g_ext
            AST_EXT_ARM_EDGE: assert property (@(posedge clk) disable iff (rst)
                $rose(ext_arm) |=> flush);                                        // R8
            AST_EXT_STAY_QUIET: assert property (@(posedge clk) disable iff (rst)
                (!flush && !$rose(ext_arm)) |=> !flush);                          // R10
        end
    endgenerate

    always_comb begin
        if (!rst) AST_NO_X_FLUSH: assert (!$isunknown(flush));                    // R1
    end
endmodule

bind flush_trigger_ctrl fltr_checker #(
    .EXT_ARM  (EXT_ARM),
    .REL_MODE (REL_MODE),
    .CHAN_W   (CHAN_W)
) i_fltr_checker (
    .clk      (clk),
    .rst      (rst),
    .seq_en   (seq_en),
    .seq_wr   (seq_wr),
    .seq_done (seq_done),
    .ext_arm  (ext_arm),
    .wr_valid (wr_valid),
    .wr_sop   (wr_sop),
    .wr_sync  (wr_sync),
    .wr_chan  (wr_chan),
    .flush    (flush)
);

// File: tb/test_flush_trigger_ctrl.sv
module test_flush_trigger_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCFG       = 5;
    localparam int CW         = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          seq_en = 1'b0, seq_wr = 1'b0, seq_done = 1'b0, ext_arm = 1'b0;
    logic          wr_valid = 1'b0, wr_sop = 1'b0, wr_sync = 1'b0;
    logic [CW-1:0] wr_chan = '0;
    logic [NCFG-1:0] flush;

    int st [NCFG];
    logic prev_m;
    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flush_trigger_ctrl #(.EXT_ARM(1'b0), .REL_MODE(fltr_pkg::REL_ANY), .CHAN_W(CW))
        i_flush_trigger_ctrl (.clk, .rst, .seq_en, .seq_wr, .seq_done, .ext_arm,
        .wr_valid, .wr_sop, .wr_sync, .wr_chan, .flush(flush[0]));
    flush_trigger_ctrl #(.EXT_ARM(1'b0), .REL_MODE(fltr_pkg::REL_SOP), .CHAN_W(CW))
        i_flush_trigger_ctrl_sop (.clk, .rst, .seq_en, .seq_wr, .seq_done, .ext_arm,
        .wr_valid, .wr_sop, .wr_sync, .wr_chan, .flush(flush[1]));
    flush_trigger_ctrl #(.EXT_ARM(1'b0), .REL_MODE(fltr_pkg::REL_SOP_SYNC), .CHAN_W(CW))
        i_flush_trigger_ctrl_sync (.clk, .rst, .seq_en, .seq_wr, .seq_done, .ext_arm,
        .wr_valid, .wr_sop, .wr_sync, .wr_chan, .flush(flush[2]));
    flush_trigger_ctrl #(.EXT_ARM(1'b0), .REL_MODE(fltr_pkg::REL_SOP_CHAN), .CHAN_W(CW),
        .NUM_CHAN(4), .START_CHAN(2))
        i_flush_trigger_ctrl_chan (.clk, .rst, .seq_en, .seq_wr, .seq_done, .ext_arm,
        .wr_valid, .wr_sop, .wr_sync, .wr_chan, .flush(flush[3]));
    flush_trigger_ctrl #(.EXT_ARM(1'b1), .REL_MODE(fltr_pkg::REL_SOP_SYNC), .CHAN_W(CW))
        i_flush_trigger_ctrl_ext (.clk, .rst, .seq_en, .seq_wr, .seq_done, .ext_arm,
        .wr_valid, .wr_sop, .wr_sync, .wr_chan, .flush(flush[4]));

    function automatic bit cfg_hit(int c);
        case (c)
            0:       return wr_valid;
            1:       return wr_valid & wr_sop;
            3:       return wr_valid & wr_sop & ((int'(wr_chan) % 4) == 2);
            default: return wr_valid & wr_sop & wr_sync;
        endcase
    endfunction

    function automatic int next_st(int c, int s, bit rise);
        bit ready = seq_en & seq_wr & ~seq_done;
        bit ext   = (c == 4);
        bit hit   = cfg_hit(c);
        case (s)
            0: begin
                if (ext && rise) return 0;
                if (hit && (ext || ready)) return 1;
                return 0;
            end
            1: begin
                if (ext && rise) return 0;
                if (!ready) return ext ? 2 : 0;
                return 1;
            end
            default: return rise ? 0 : 2;
        endcase
    endfunction

    function automatic string tag_of(int c);
        case (c)
            0: return "R3/R2/R7";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R8/R9/R10";
        endcase
    endfunction

    task automatic chk(logic act, logic exp, string tag, string what);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        bit rise;
        @(posedge clk);
        rise = ext_arm & ~prev_m;
        for (int c = 0; c < NCFG; c++)
            st[c] = rst ? 0 : next_st(c, st[c], rise);
        prev_m = rst ? 1'b0 : ext_arm;
        @(negedge clk);
        for (int c = 0; c < NCFG; c++)
            chk(flush[c], st[c] == 0, tag_of(c), $sformatf("model cfg%0d", c));
    endtask

    task automatic drive(bit en, bit wr, bit dn, bit v, bit s, bit sy, int ch, bit arm);
        seq_en = en; seq_wr = wr; seq_done = dn;
        wr_valid = v; wr_sop = s; wr_sync = sy; wr_chan = CW'(ch); ext_arm = arm;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int c = 0; c < NCFG; c++) st[c] = 0;
        prev_m = 1'b0;
        void'($urandom(32'h5eed_f1c3));
        repeat (3) tick();
        rst = 1'b0;
        for (int c = 0; c < NCFG; c++) chk(flush[c], 1'b1, "R1", "reset value");
        tick();
        for (int c = 0; c < NCFG; c++) chk(flush[c], 1'b1, "R1", "first cycle after reset");

        // sequencer not enabled, releasing beat for every mode
        drive(0, 1, 0, 1, 1, 1, 2, 0); tick();
        chk(flush[0], 1'b1, "R2", "not ready keeps flush");
        chk(flush[4], 1'b0, "R9", "ext release while sequencer idle");
        // ready, valid without sop
        drive(1, 1, 0, 1, 0, 0, 0, 0); tick();
        chk(flush[0], 1'b0, "R3", "any beat releases");
        chk(flush[1], 1'b1, "R4", "no sop keeps flush");
        drive(1, 1, 0, 1, 1, 0, 0, 0); tick();
        chk(flush[1], 1'b0, "R4", "sop releases");
        chk(flush[2], 1'b1, "R5", "sop without sync keeps flush");
        drive(1, 1, 0, 1, 1, 1, 1, 0); tick();
        chk(flush[2], 1'b0, "R5", "sop with sync releases");
        chk(flush[3], 1'b1, "R6", "channel 1 keeps flush");
        drive(1, 1, 0, 1, 1, 0, 6, 0); tick();
        chk(flush[3], 1'b0, "R6", "channel 6 aliases to 2");
        // stream idle, arm rises
        drive(1, 1, 0, 0, 0, 0, 0, 1); tick();
        chk(flush[0], 1'b0, "R7", "released stays low");
        chk(flush[0], 1'b0, "R11", "arm ignored internally");
        chk(flush[4], 1'b1, "R8", "rising arm sets flush");
        drive(1, 1, 0, 1, 1, 1, 2, 1); tick();
        chk(flush[4], 1'b0, "R9", "ext armed release");
        for (int c = 0; c < 4; c++) chk(flush[c], 1'b0, "R7", "stream activity no reflush");
        // write ends
        drive(1, 1, 1, 0, 0, 0, 0, 1); tick();
        chk(flush[0], 1'b1, "R2", "done reflushes");
        chk(flush[4], 1'b0, "R10", "ext no flush after end");
        drive(1, 1, 0, 0, 0, 0, 0, 1);
        repeat (3) begin
            tick();
            chk(flush[4], 1'b0, "R10", "held arm does not re-arm");
            chk(flush[0], 1'b1, "R11", "held arm no effect internal");
        end
        drive(1, 1, 0, 0, 0, 0, 0, 0); tick();
        drive(1, 1, 0, 0, 0, 0, 0, 1); tick();
        chk(flush[4], 1'b1, "R8", "new edge re-arms");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            bit arm_n = ext_arm;
            if ($urandom_range(0, 19) == 0) arm_n = ~ext_arm;
            drive($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
                  $urandom_range(0, 15) == 0, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                  int'($urandom_range(0, 7)), arm_n);
            tick();
        end
        finish_run();
    end
endmodule